// File: doc/BRIEF.md
# Pipelined Dot-Product Multiply-Accumulate Unit

This block computes the dot product of two 16-element vectors of 16-bit operands and accumulates the result into a 32-bit register. Element pairs enter through a valid/ready handshake, one pair per clock at most. Each pair is first captured in an input latch, so the source can offer the next pair while earlier ones are still being multiplied. The multiplier is a shift-and-add array. Each of its adder stages has a register on both sides, so no combinational path crosses more than one adder. Successive products travel through the array one stage behind one another, and up to a whole vector's worth of products is in flight at the same time.

When the last product of a vector has been added, the block raises a result-valid flag and holds the accumulator on the result port until it is taken. After the result is taken, the next vector adds onto the same accumulator. A clear pulse zeroes the accumulator, abandons any work in flight and starts a fresh dot product. Each pair carries its own sign-mode bit, which selects two's-complement or unsigned multiplication.

Top module: `serial_dot_mac`

## Requirements
- R1: After reset, `resValid` is 0, `inReady` is 1, and the accumulator starts from zero.
- R2: `inReady` stays high until 16 pairs of the current vector have been accepted. It then stays low until the result is taken. Pairs offered while it is low are ignored.
- R3: With `signedMode`=0 a pair contributes the unsigned product of `inX` and `inY`.
- R4: With `signedMode`=1 a pair contributes the two's-complement product of `inX` and `inY`, sign-extended to 32 bits.
- R5: `signedMode` is sampled together with each pair, so one vector may mix signed and unsigned pairs.
- R6: `resValid` rises exactly 17 rising edges after the edge that accepted the 16th pair. At that point `resData` equals the accumulator plus the sum of the 16 products.
- R7: A pair can be accepted on every cycle with no gaps, and gaps of any length between pairs are also allowed.
- R8: While `resValid` is 1 and `resReady` is 0, `resValid` and `resData` hold steady.
- R9: A cycle with `resValid` and `resReady` both high takes the result: `resValid` falls at that edge and `inReady` returns. The accumulator keeps its value, so the next vector adds onto it.
- R10: While `clear` is high, `inReady` is 0. At the edge, `clear` zeroes the accumulator, drops `resValid` and discards every pair that has been accepted or is in flight.
- R11: Accumulation wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of the dot product; zeroes the accumulator |
| signedMode | input | 1 | 1: two's-complement pair, 0: unsigned pair |
| inValid | input | 1 | Operand pair offered |
| inReady | output | 1 | Operand pair can be accepted |
| inX | input | OP_W | First operand of the pair |
| inY | input | OP_W | Second operand of the pair |
| resValid | output | 1 | Dot product complete, result held |
| resReady | input | 1 | Result taken when high with resValid |
| resData | output | 2*OP_W | Accumulator value |

## Verification
An accepted pair reaches the input latch at its acceptance edge and the first adder stage one edge later. It leaves the sixteenth stage at the sixteenth edge and lands in the accumulator at the seventeenth, so the result of a vector is due 17 edges after its last acceptance. `inReady` reacts to `clear` within the same cycle and drops at the edge that accepts the sixteenth pair. The bench keeps a queue of pending products, each stamped with the edge number at which it is due. At every rising edge it advances this model, and in the middle of every cycle it compares `inReady`, `resValid` and `resData` against the model, so an early or late result is reported in the cycle where it happens.

// File: rtl/dot_mac_pkg.sv
package dot_mac_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture the offered pair into the input latch
    logic flush;  // drop everything in flight and zero the accumulator
  } dmStrobe_t;
endpackage

// File: rtl/dot_mac_ctrl.sv
module dot_mac_ctrl
  import dot_mac_pkg::*;
#(
  parameter int VEC_LEN = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      clear,
  input  logic      inValid,
  input  logic      resReady,
  input  logic      prodValid,
  output logic      inReady,
  output logic      resValid,
  output dmStrobe_t strobe
);
  localparam int CW = $clog2(VEC_LEN + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(VEC_LEN);
  localparam logic [CW-1:0] LAST_CNT = CW'(VEC_LEN - 1);

  logic [CW-1:0] inCnt;
  logic [CW-1:0] prodCnt;
  logic          take;

  assign take         = resValid && resReady;
  assign inReady      = !clear && !resValid && (inCnt != FULL_CNT);
  assign strobe.load  = inValid && inReady;
  assign strobe.flush = clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt    <= '0;
      prodCnt  <= '0;
      resValid <= 1'b0;
    end else if (clear || take) begin
      inCnt    <= '0;
      prodCnt  <= '0;
      resValid <= 1'b0;
    end else begin
      if (strobe.load) inCnt <= inCnt + 1'b1;
      if (prodValid) begin
        prodCnt <= prodCnt + 1'b1;
        if (prodCnt == LAST_CNT) resValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dot_mac_dp.sv
module dot_mac_dp
  import dot_mac_pkg::*;
#(
  parameter int OP_W = 16,
  localparam int PW  = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  dmStrobe_t       strobe,
  input  logic            signedMode,
  input  logic [OP_W-1:0] inX,
  input  logic [OP_W-1:0] inY,
  output logic            prodValid,
  output logic [PW-1:0]   accOut
);
  // Input latch: frees the handshake while earlier pairs are in the array
  logic [OP_W-1:0] xL, yL;
  logic            sL, vL;
  logic [PW-1:0]   xExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vL <= 1'b0;
    else       vL <= strobe.load;
  end

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      xL <= inX;
      yL <= inY;
      sL <= signedMode;
    end
  end

  assign xExt = {{OP_W{sL & xL[OP_W-1]}}, xL};

  // Staggered array: one adder per stage, registered on both sides.
  // Stage k consumes multiplier bit k; the remaining bits shift onward.
  for (genvar k = 0; k < OP_W; k++) begin : stg
    localparam int  REM      = OP_W - 1 - k;
    localparam bit  NEG_STEP = (k == OP_W - 1);

    logic [PW-1:0] accIn, candIn, shifted, sum;
    logic          bitIn, sgnIn, vldIn;
    logic [PW-1:0] accQ;
    logic          vldQ;

    if (k == 0) begin : src
      assign accIn  = '0;
      assign candIn = xExt;
      assign bitIn  = yL[0];
      assign sgnIn  = sL;
      assign vldIn  = vL;
    end else begin : src
      assign accIn  = stg[k-1].accQ;
      assign candIn = stg[k-1].fwd.candQ;
      assign bitIn  = stg[k-1].fwd.plierQ[0];
      assign sgnIn  = stg[k-1].fwd.sgnQ;
      assign vldIn  = stg[k-1].vldQ;
    end

    assign shifted = candIn << k;

    always_comb begin
      if (!bitIn)                  sum = accIn;
      else if (NEG_STEP && sgnIn)  sum = accIn - shifted;  // weight -2^(W-1)
      else                         sum = accIn + shifted;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             vldQ <= 1'b0;
      else if (strobe.flush) vldQ <= 1'b0;
      else                   vldQ <= vldIn;
    end

    always_ff @(posedge clk) accQ <= sum;

    if (k < OP_W - 1) begin : fwd
      logic [PW-1:0]  candQ;
      logic [REM-1:0] plierQ;
      logic           sgnQ;
      logic [REM-1:0] restIn;

      if (k == 0) begin : rest
        assign restIn = yL[OP_W-1:1];
      end else begin : rest
        assign restIn = stg[k-1].fwd.plierQ[REM:1];
      end

      always_ff @(posedge clk) begin
        candQ  <= candIn;
        plierQ <= restIn;
        sgnQ   <= sgnIn;
      end
    end
  end

  assign prodValid = stg[OP_W-1].vldQ;

  // Accumulator, read and written back in place, wrapping at 2^PW
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             accOut <= '0;
    else if (strobe.flush) accOut <= '0;
    else if (prodValid)    accOut <= accOut + stg[OP_W-1].accQ;
  end
endmodule

// File: rtl/serial_dot_mac.sv
module serial_dot_mac
  import dot_mac_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int VEC_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              signedMode,
  input  logic              inValid,
  output logic              inReady,
  input  logic [OP_W-1:0]   inX,
  input  logic [OP_W-1:0]   inY,
  output logic              resValid,
  input  logic              resReady,
  output logic [2*OP_W-1:0] resData
);
  dmStrobe_t strobe;
  logic      prodValid;

  dot_mac_ctrl #(.VEC_LEN(VEC_LEN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .inValid   (inValid),
    .resReady  (resReady),
    .prodValid (prodValid),
    .inReady   (inReady),
    .resValid  (resValid),
    .strobe    (strobe)
  );

  dot_mac_dp #(.OP_W(OP_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .signedMode (signedMode),
    .inX        (inX),
    .inY        (inY),
    .prodValid  (prodValid),
    .accOut     (resData)
  );
endmodule

// File: rtl/serial_dot_mac_chk.sv
module serial_dot_mac_chk #(
  parameter int OP_W    = 16,
  parameter int VEC_LEN = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic              inValid,
  input logic              inReady,
  input logic              resValid,
  input logic              resReady,
  input logic [2*OP_W-1:0] resData
);
  localparam int SW = $clog2(VEC_LEN + 1);
  localparam int TW = $clog2(OP_W + 2);
  localparam logic [SW-1:0] LAST_SEEN = SW'(VEC_LEN - 1);
  localparam logic [TW-1:0] DUE_TMR   = TW'(OP_W);

  logic [SW-1:0] seen;
  logic [TW-1:0] tmr;
  logic          armed;

  // Latency window tracked with a counter, not a deep $past
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen <= '0; tmr <= '0; armed <= 1'b0;
    end else if (clear || (resValid && resReady)) begin
      seen <= '0; tmr <= '0; armed <= 1'b0;
    end else if (inValid && inReady) begin
      seen <= seen + 1'b1;
      if (seen == LAST_SEEN) begin
        armed <= 1'b1;
        tmr   <= '0;
      end
    end else if (armed && tmr <= DUE_TMR) begin
      tmr <= tmr + 1'b1;
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !resValid);

  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !inReady);

  // R6
  lat_early_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && tmr <= DUE_TMR) |-> !resValid);

  // R6
  lat_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && tmr == DUE_TMR && !clear) |=> resValid);

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady && !clear) |=> (resValid && $stable(resData)));

  // R9
  res_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resReady) |=> !resValid);

  // R10
  clr_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> !inReady);

  // R10
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!resValid && resData == '0));
endmodule

bind serial_dot_mac serial_dot_mac_chk #(.OP_W(OP_W), .VEC_LEN(VEC_LEN)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clear    (clear),
  .inValid  (inValid),
  .inReady  (inReady),
  .resValid (resValid),
  .resReady (resReady),
  .resData  (resData)
);

// File: tb/serial_dot_mac_tb.sv
`timescale 1ns/1ps
module serial_dot_mac_tb;
  localparam int OW = 16;
  localparam int VL = 16;
  localparam int PW = 2 * OW;

  logic          clk = 1'b0;
  logic          rstN, clear, signedMode, inValid, resReady;
  logic [OW-1:0] inX, inY;
  logic          inReady, resValid;
  logic [PW-1:0] resData;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  always #4 clk = ~clk;  // 125 MHz

  serial_dot_mac #(.OP_W(OW), .VEC_LEN(VL)) u_dut (
    .clk(clk), .rstN(rstN), .clear(clear), .signedMode(signedMode),
    .inValid(inValid), .inReady(inReady), .inX(inX), .inY(inY),
    .resValid(resValid), .resReady(resReady), .resData(resData)
  );

  // ---------------- behavioural reference ----------------
  logic [PW-1:0] mAcc;
  int            mCnt, mProd, cyc;
  bit            mResValid, mAccept;
  int            dueQ[$];
  logic [PW-1:0] prodQ[$];

  function automatic bit mReady();
    return !clear && !mResValid && (mCnt < VL);
  endfunction

  function automatic logic [PW-1:0] refProd(logic [OW-1:0] a, logic [OW-1:0] b, bit s);
    longint la, lb, p;
    la = s ? longint'($signed(a)) : longint'(a);
    lb = s ? longint'($signed(b)) : longint'(b);
    p  = la * lb;
    return p[PW-1:0];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mAcc = '0; mCnt = 0; mProd = 0; mResValid = 0; cyc = 0;
      dueQ.delete(); prodQ.delete();
    end else begin
      cyc++;
      if (clear) begin
        mAcc = '0; mCnt = 0; mProd = 0; mResValid = 0;
        dueQ.delete(); prodQ.delete();
      end else begin
        mAccept = inValid && mReady();
        if (mResValid && resReady) begin
          mResValid = 0; mCnt = 0; mProd = 0;
        end
        while (dueQ.size() > 0 && dueQ[0] == cyc) begin
          void'(dueQ.pop_front());
          mAcc = mAcc + prodQ.pop_front();
          mProd++;
          if (mProd == VL) mResValid = 1;
        end
        if (mAccept) begin
          dueQ.push_back(cyc + OW + 1);
          prodQ.push_back(refProd(inX, inY, signedMode));
          mCnt++;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Mid-cycle comparison against the reference on every clock
  always begin
    @(negedge clk);
    #2;
    if (rstN) begin
      chk("R2", "inReady", PW'(inReady), PW'(mReady()));
      chk("R6", "resValid", PW'(resValid), PW'(mResValid));
      if (mResValid) chk(curReq, "resData", resData, mAcc);
    end
  end

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic sendPair(logic [OW-1:0] a, logic [OW-1:0] b, bit s);
    inX = a; inY = b; signedMode = s; inValid = 1'b1;
    while (!mReady()) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitResult(int hold);
    while (!mResValid) @(negedge clk);
    inX = 16'hDEAD; inY = 16'hBEEF; inValid = 1'b1;  // R2: offered while full, must be ignored
    repeat (hold) @(negedge clk);                     // R8: held while not taken
    inValid = 1'b0;
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
  endtask

  task automatic clearPulse();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  logic [OW-1:0] edgeA[6] = '{16'h8000, 16'h8000, 16'h7FFF, 16'hFFFF, 16'hFFFF, 16'h0001};
  logic [OW-1:0] edgeB[6] = '{16'h8000, 16'h7FFF, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hFFFF};

  initial begin
    rstN = 1'b0; clear = 1'b0; signedMode = 1'b0; inValid = 1'b0;
    resReady = 1'b0; inX = '0; inY = '0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "resValid in reset", PW'(resValid), '0);
    chk("R1", "inReady in reset", PW'(inReady), PW'(1));
    chk("R1", "accumulator in reset", resData, '0);
    @(negedge clk);
    rstN = 1'b1;

    // R3 + R7: unsigned, back-to-back, result held before take (R8)
    curReq = "R3";
    for (int i = 0; i < VL; i++) sendPair(OW'($urandom), OW'($urandom), 1'b0);
    waitResult(4);

    // R4: signed extremes
    clearPulse();
    curReq = "R4";
    for (int i = 0; i < VL; i++) begin
      if (i < 6) sendPair(edgeA[i], edgeB[i], 1'b1);
      else       sendPair(OW'($urandom), OW'($urandom), 1'b1);
    end
    waitResult(2);

    // R5: mode alternates pair by pair
    clearPulse();
    curReq = "R5";
    for (int i = 0; i < VL; i++) sendPair(OW'($urandom) | 16'h8000, OW'($urandom), i[0]);
    waitResult(1);

    // R7 + R2: gaps between pairs, extra pair offered after the 16th
    clearPulse();
    curReq = "R7";
    for (int i = 0; i < VL; i++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      sendPair(OW'($urandom), OW'($urandom), 1'($urandom));
    end
    inX = 16'h1234; inY = 16'h5678; inValid = 1'b1;  // R2: ignored
    repeat (5) @(negedge clk);
    inValid = 1'b0;
    waitResult(0);

    // R9: no clear, next vector adds onto the kept accumulator
    #2;
    chk("R9", "inReady after take", PW'(inReady), PW'(1));
    chk("R9", "resValid after take", PW'(resValid), '0);
    @(negedge clk);
    curReq = "R9";
    for (int i = 0; i < VL; i++) sendPair(OW'($urandom), OW'($urandom), 1'b0);
    waitResult(1);

    // R11: wrap modulo 2^32
    clearPulse();
    curReq = "R11";
    for (int i = 0; i < VL; i++) sendPair(16'hFFFF, 16'hFFFF, 1'b0);
    waitResult(0);
    #2;
    chk("R11", "wrapped sum", resData, 32'hFFE0_0010);
    @(negedge clk);

    // R10: clear with pairs in flight
    clearPulse();
    curReq = "R10";
    for (int i = 0; i < 6; i++) sendPair(16'h0100, 16'h0100, 1'b0);
    repeat (3) @(negedge clk);
    clear = 1'b1;
    #2;
    chk("R10", "inReady during clear", PW'(inReady), '0);
    @(negedge clk);
    clear = 1'b0;
    #2;
    chk("R10", "accumulator after clear", resData, '0);
    @(negedge clk);
    for (int i = 0; i < VL; i++) sendPair(16'd1, 16'd1, 1'b0);
    waitResult(0);
    #2;
    chk("R10", "in-flight pairs discarded", resData, 32'd16);
    @(negedge clk);

    // R10: clear while a result is waiting
    for (int i = 0; i < VL; i++) sendPair(16'd5, 16'd7, 1'b0);
    while (!mResValid) @(negedge clk);
    clearPulse();
    #2;
    chk("R10", "resValid dropped by clear", PW'(resValid), '0);
    chk("R10", "accumulator zeroed", resData, '0);
    @(negedge clk);
    for (int i = 0; i < VL; i++) sendPair(16'd2, 16'd3, 1'b0);
    waitResult(0);
    #2;
    chk("R10", "fresh sum after clear", resData, 32'd96);
    @(negedge clk);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule